// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block drives a parameterized up-counter (16 bits by default) from one chosen trigger line. A trigger selector picks the trigger from five candidates: an internal trigger, a detector that pulses on every change of timer input 1, the filtered level of timer input 1, the filtered level of timer input 2, and the filtered external trigger. A mode field then decides what a trigger does to the counter. It can restart the counter with an update event, gate the count by level, start the count without clearing it, or act as the count clock. With the mode off, the counter simply advances every clock while enabled.

All trigger inputs are assumed to be already synchronized and filtered. A sync option delays the trigger's effect by one clock. The undelayed rising edge goes out on the trigger output. A timer chained from that output then stays in step with this one. Configuration is written through a one-cycle write strobe. The counter enable is set and cleared by separate strobes, and trigger-start mode can also set it.

Top module: `tsc_top`

## Requirements
- R1: After a synchronous reset the count is 0, the enable is 0, the update strobe is 0, the mode is off (000), the trigger selector is 000 and the sync option is off.
- R2: Selector code 000 picks the internal trigger, 100 the change detector on input 1, 101 the input 1 level, 110 the input 2 level and 111 the external trigger. Codes 001 to 011 give a constant low trigger.
- R3: A configuration write always loads the mode and the sync bit. It loads the selector only if the mode in force before the write is 000; otherwise the old selector stays in use.
- R4: In mode 000 the counter increments once per clock while enabled. Going from all ones to 0 raises the update strobe for one cycle.
- R5: In mode 100 a rising trigger edge sets the counter to 0 and raises the update strobe for one cycle. Otherwise the counter counts as in mode 000.
- R6: In mode 101 the counter increments only in clocks where the enable is set and the trigger is high. When the trigger is low it holds its value and is not cleared. With selector 100 the counter never moves in this mode.
- R7: In mode 110 a rising trigger edge sets the enable. The count is never cleared, and it begins on the clock after the edge.
- R8: In mode 111 the counter increments by one on each rising trigger edge, but only while the enable is set.
- R9: With the sync bit set, the trigger acts on the counter one clock later than without it. The trigger output pulses high combinationally in the cycle the undelayed selected trigger first reads high.
- R10: The enable-clear strobe has priority over the enable-set strobe and over a trigger start.
- R11: The change detector produces one trigger pulse for each rising and each falling transition of input 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tsel | input | 3 | Trigger selector value to write |
| cfg_mode | input | 3 | Mode value to write |
| cfg_sync | input | 1 | Sync (one-clock trigger delay) value to write |
| en_set | input | 1 | Set counter enable |
| en_clr | input | 1 | Clear counter enable |
| itrig | input | 1 | Internal trigger |
| tin1 | input | 1 | Filtered timer input 1 |
| tin2 | input | 1 | Filtered timer input 2 |
| xtrig | input | 1 | Filtered external trigger |
| count | output | CNT_W | Counter value |
| cnt_en | output | 1 | Counter enable state |
| upd_evt | output | 1 | Update event strobe |
| trig_out | output | 1 | Undelayed trigger rising-edge pulse |

## Verification
On every cycle the assertions check the per-mode counter rules. These are the free-running increment, the restart to zero with update, the hold while the gate is closed or the configuration is invalid, the idle external-clock hold, the start of counting in trigger mode and the clear-strobe priority. They also check that the selector survives writes made while a mode is active. Only the bench scenarios can show that each selector code routes the intended input and that the change detector fires on both transitions. The same holds for the extra clock of latency the sync option adds against the undelayed output pulse, and for the exact cycle of counter wrap-around.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [2:0] {
        TS_INT0  = 3'b000,
        TS_RSV1  = 3'b001,
        TS_RSV2  = 3'b010,
        TS_RSV3  = 3'b011,
        TS_EDGE1 = 3'b100,
        TS_LVL1  = 3'b101,
        TS_LVL2  = 3'b110,
        TS_EXT   = 3'b111
    } tsel_e;

    typedef enum logic [2:0] {
        SM_OFF     = 3'b000,
        SM_QD1     = 3'b001,
        SM_QD2     = 3'b010,
        SM_QD3     = 3'b011,
        SM_RESTART = 3'b100,
        SM_GATE    = 3'b101,
        SM_START   = 3'b110,
        SM_EXTCLK  = 3'b111
    } smode_e;

    typedef struct packed {
        tsel_e  tsel;
        smode_e mode;
        logic   sync;
    } cfg_t;

    typedef struct packed {
        logic lvl;
        logic rise;
    } trig_t;

    typedef struct packed {
        logic inc;
        logic clr;
        logic start;
    } act_t;

    function automatic logic gate_invalid(input cfg_t c);
        return (c.mode == SM_GATE) && (c.tsel == TS_EDGE1);
    endfunction

endpackage

// File: rtl/tsc_trig.sv
module tsc_trig
    import tsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tsel_e tsel,
    input  logic  sync,
    input  logic  itrig,
    input  logic  tin1,
    input  logic  tin2,
    input  logic  xtrig,
    output trig_t trg,
    output logic  rise_raw
);
    logic tin1_q;
    logic chg1;
    logic sel;
    logic sel_q;
    logic sel_qq;
    logic eff;
    logic eff_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            tin1_q <= 1'b0;
            sel_q  <= 1'b0;
            sel_qq <= 1'b0;
        end else begin
            tin1_q <= tin1;
            sel_q  <= sel;
            sel_qq <= sel_q;
        end
    end

    assign chg1 = tin1 ^ tin1_q;

    always_comb begin
        unique case (tsel)
            TS_INT0:  sel = itrig;
            TS_EDGE1: sel = chg1;
            TS_LVL1:  sel = tin1;
            TS_LVL2:  sel = tin2;
            TS_EXT:   sel = xtrig;
            default:  sel = 1'b0;
        endcase
    end

    assign rise_raw = sel & ~sel_q;
    assign eff      = sync ? sel_q  : sel;
    assign eff_prev = sync ? sel_qq : sel_q;
    assign trg.lvl  = eff;
    assign trg.rise = eff & ~eff_prev;

endmodule

// File: rtl/tsc_mode.sv
module tsc_mode
    import tsc_pkg::*;
(
    input  cfg_t  cfg,
    input  logic  en,
    input  trig_t trg,
    output act_t  act
);
    always_comb begin
        act = '0;
        unique case (cfg.mode)
            SM_OFF: act.inc = en;
            SM_RESTART: begin
                act.clr = trg.rise;
                act.inc = en & ~trg.rise;
            end
            SM_GATE:   act.inc = en & trg.lvl & ~gate_invalid(cfg);
            SM_START: begin
                act.inc   = en;
                act.start = trg.rise;
            end
            SM_EXTCLK: act.inc = en & trg.rise;
            default:   act = '0;
        endcase
    end
endmodule

// File: rtl/tsc_count.sv
module tsc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             upd
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            upd <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            upd <= 1'b1;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            upd <= (cnt == TOP);
        end else begin
            upd <= 1'b0;
        end
    end
endmodule

// File: rtl/tsc_top.sv
module tsc_top
    import tsc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_tsel,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_sync,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             itrig,
    input  logic             tin1,
    input  logic             tin2,
    input  logic             xtrig,
    output logic [CNT_W-1:0] count,
    output logic             cnt_en,
    output logic             upd_evt,
    output logic             trig_out
);
    cfg_t  cfg_q;
    logic  en_q;
    trig_t trg;
    act_t  act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.tsel <= TS_INT0;
            cfg_q.mode <= SM_OFF;
            cfg_q.sync <= 1'b0;
        end else if (cfg_wr) begin
            cfg_q.mode <= smode_e'(cfg_mode);
            cfg_q.sync <= cfg_sync;
            if (cfg_q.mode == SM_OFF)
                cfg_q.tsel <= tsel_e'(cfg_tsel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (en_clr)
            en_q <= 1'b0;
        else if (en_set || act.start)
            en_q <= 1'b1;
    end

    tsc_trig u_trig (
        .clk      (clk),
        .rst      (rst),
        .tsel     (cfg_q.tsel),
        .sync     (cfg_q.sync),
        .itrig    (itrig),
        .tin1     (tin1),
        .tin2     (tin2),
        .xtrig    (xtrig),
        .trg      (trg),
        .rise_raw (trig_out)
    );

    tsc_mode u_mode (
        .cfg (cfg_q),
        .en  (en_q),
        .trg (trg),
        .act (act)
    );

    tsc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (act.inc),
        .clr (act.clr),
        .cnt (count),
        .upd (upd_evt)
    );

    assign cnt_en = en_q;

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
    import tsc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             en_clr,
    input cfg_t             cfg_q,
    input trig_t            trg,
    input logic [CNT_W-1:0] count,
    input logic             cnt_en,
    input logic             upd_evt
);
    // R3: selector survives writes made while a mode is active
    p_tsel_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_q.mode != SM_OFF) |=> $stable(cfg_q.tsel));

    // R4: free-running increment while enabled in mode off
    p_free_run_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_OFF && cnt_en) |=> (count == $past(count) + 1'b1));

    // R4 / R5: an update only accompanies a zero count
    p_upd_zero_r4: assert property (@(posedge clk) disable iff (rst)
        upd_evt |-> (count == '0));

    // R5: restart on rising trigger
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_RESTART && trg.rise) |=> (count == '0 && upd_evt));

    // R6: closed gate or invalid selector holds the count
    p_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_GATE && (!trg.lvl || cfg_q.tsel == TS_EDGE1)) |=> $stable(count));

    // R7: trigger start sets the enable
    p_start_en_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_START && trg.rise && !en_clr) |=> cnt_en);

    // R8: no edge, no external-clock step
    p_ext_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_EXTCLK && !trg.rise) |=> $stable(count));

    // R10: clear strobe wins
    p_clr_wins_r10: assert property (@(posedge clk) disable iff (rst)
        en_clr |=> !cnt_en);
endmodule

bind tsc_top tsc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (cfg_wr),
    .en_clr  (en_clr),
    .cfg_q   (cfg_q),
    .trg     (trg),
    .count   (count),
    .cnt_en  (cnt_en),
    .upd_evt (upd_evt)
);

// File: tb/tsc_top_test.sv
`timescale 1ns/1ps
module tsc_top_test;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_tsel = 3'd0;
    logic [2:0] cfg_mode = 3'd0;
    logic cfg_sync = 1'b0;
    logic en_set = 1'b0;
    logic en_clr = 1'b0;
    logic itrig = 1'b0;
    logic tin1 = 1'b0;
    logic tin2 = 1'b0;
    logic xtrig = 1'b0;
    logic [CNT_W-1:0] count;
    logic cnt_en;
    logic upd_evt;
    logic trig_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             upd;
        string            req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    tsc_top #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_tsel(cfg_tsel),
        .cfg_mode(cfg_mode), .cfg_sync(cfg_sync), .en_set(en_set),
        .en_clr(en_clr), .itrig(itrig), .tin1(tin1), .tin2(tin2),
        .xtrig(xtrig), .count(count), .cnt_en(cnt_en),
        .upd_evt(upd_evt), .trig_out(trig_out)
    );

    // monitor: compare after each edge against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (count !== it.cnt || cnt_en !== it.en || upd_evt !== it.upd) begin
                    errors++;
                    $display("FAIL %s: count=%0d en=%0b upd=%0b expected count=%0d en=%0b upd=%0b",
                             it.req, count, cnt_en, upd_evt, it.cnt, it.en, it.upd);
                end
            end
        end
    end

    task automatic tick(input logic [CNT_W-1:0] c, input logic e, input logic u, input string r);
        exp_t it;
        it.cnt = c; it.en = e; it.upd = u; it.req = r;
        sb.push_back(it);
        @(posedge clk);
        #2;
        cfg_wr = 1'b0;
        en_set = 1'b0;
        en_clr = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] ts, input logic [2:0] md, input logic sy);
        cfg_wr = 1'b1; cfg_tsel = ts; cfg_mode = md; cfg_sync = sy;
    endtask

    task automatic chk_trig(input logic exp, input string r);
        #1;
        checks++;
        if (trig_out !== exp) begin
            errors++;
            $display("FAIL %s: trig_out=%0b expected %0b", r, trig_out, exp);
        end
    endtask

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        tick(16'd0, 1'b0, 1'b0, "R1");
        tick(16'd0, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        // R4 / R10 free run and enable strobes
        en_set = 1'b1; tick(16'd0, 1'b1, 1'b0, "R4");
        tick(16'd1, 1'b1, 1'b0, "R4");
        tick(16'd2, 1'b1, 1'b0, "R4");
        tick(16'd3, 1'b1, 1'b0, "R4");
        en_set = 1'b1; en_clr = 1'b1; tick(16'd4, 1'b0, 1'b0, "R10");
        tick(16'd4, 1'b0, 1'b0, "R10");
        // R5 restart, internal trigger (R2 code 000)
        cfg(3'b000, 3'b100, 1'b0); en_set = 1'b1; tick(16'd4, 1'b1, 1'b0, "R5");
        tick(16'd5, 1'b1, 1'b0, "R5");
        itrig = 1'b1; tick(16'd0, 1'b1, 1'b1, "R5");
        tick(16'd1, 1'b1, 1'b0, "R5");
        itrig = 1'b0; tick(16'd2, 1'b1, 1'b0, "R5");
        // R4 wrap-around
        repeat (65532) @(posedge clk);
        #2;
        tick(16'hFFFF, 1'b1, 1'b0, "R4");
        tick(16'd0, 1'b1, 1'b1, "R4");
        tick(16'd1, 1'b1, 1'b0, "R4");
        // R3 selector write ignored while mode active
        cfg(3'b101, 3'b100, 1'b0); tick(16'd2, 1'b1, 1'b0, "R3");
        tin1 = 1'b1; tick(16'd3, 1'b1, 1'b0, "R3");
        tin1 = 1'b0; cfg(3'b101, 3'b000, 1'b0); tick(16'd4, 1'b1, 1'b0, "R3");
        // R6 gated on input 1 level (R2 code 101)
        cfg(3'b101, 3'b101, 1'b0); tick(16'd5, 1'b1, 1'b0, "R6");
        tick(16'd5, 1'b1, 1'b0, "R6");
        tin1 = 1'b1; tick(16'd6, 1'b1, 1'b0, "R6");
        tick(16'd7, 1'b1, 1'b0, "R6");
        tin1 = 1'b0; tick(16'd7, 1'b1, 1'b0, "R6");
        // R6 invalid gate with change detector
        cfg(3'b101, 3'b000, 1'b0); tick(16'd7, 1'b1, 1'b0, "R6");
        cfg(3'b100, 3'b101, 1'b0); tick(16'd8, 1'b1, 1'b0, "R6");
        tin1 = 1'b1; tick(16'd8, 1'b1, 1'b0, "R6");
        tick(16'd8, 1'b1, 1'b0, "R6");
        tin1 = 1'b0; tick(16'd8, 1'b1, 1'b0, "R6");
        // R8 external clock on input 2 (R2 code 110)
        cfg(3'b100, 3'b000, 1'b0); tick(16'd8, 1'b1, 1'b0, "R6");
        cfg(3'b110, 3'b111, 1'b0); tick(16'd9, 1'b1, 1'b0, "R8");
        tick(16'd9, 1'b1, 1'b0, "R8");
        tin2 = 1'b1; tick(16'd10, 1'b1, 1'b0, "R8");
        tick(16'd10, 1'b1, 1'b0, "R8");
        tin2 = 1'b0; tick(16'd10, 1'b1, 1'b0, "R8");
        tin2 = 1'b1; tick(16'd11, 1'b1, 1'b0, "R8");
        tin2 = 1'b0;
        // R11 change detector clocks both transitions (R2 code 100)
        cfg(3'b110, 3'b000, 1'b0); tick(16'd11, 1'b1, 1'b0, "R8");
        cfg(3'b100, 3'b111, 1'b0); tick(16'd12, 1'b1, 1'b0, "R11");
        tin1 = 1'b1; tick(16'd13, 1'b1, 1'b0, "R11");
        tick(16'd13, 1'b1, 1'b0, "R11");
        tin1 = 1'b0; tick(16'd14, 1'b1, 1'b0, "R11");
        tick(16'd14, 1'b1, 1'b0, "R11");
        // R8 needs the enable
        en_clr = 1'b1; tick(16'd14, 1'b0, 1'b0, "R8");
        tin1 = 1'b1; tick(16'd14, 1'b0, 1'b0, "R8");
        // R7 trigger start on external trigger (R2 code 111)
        cfg(3'b100, 3'b000, 1'b0); tick(16'd14, 1'b0, 1'b0, "R7");
        cfg(3'b111, 3'b110, 1'b0); tick(16'd14, 1'b0, 1'b0, "R7");
        xtrig = 1'b1; chk_trig(1'b1, "R9");
        tick(16'd14, 1'b1, 1'b0, "R7");
        tick(16'd15, 1'b1, 1'b0, "R7");
        xtrig = 1'b0; tick(16'd16, 1'b1, 1'b0, "R7");
        // R9 sync delay in restart mode
        cfg(3'b000, 3'b000, 1'b0); tick(16'd17, 1'b1, 1'b0, "R9");
        cfg(3'b111, 3'b100, 1'b1); tick(16'd18, 1'b1, 1'b0, "R9");
        xtrig = 1'b1; chk_trig(1'b1, "R9");
        tick(16'd19, 1'b1, 1'b0, "R9");
        chk_trig(1'b0, "R9");
        tick(16'd0, 1'b1, 1'b1, "R9");
        tick(16'd1, 1'b1, 1'b0, "R9");
        xtrig = 1'b0; tick(16'd2, 1'b1, 1'b0, "R9");
        @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule